// File: doc/BRIEF.md
# Regulator Fault Supervisor with Power-Good

This block watches a multiphase buck regulator from the digital side. Each clock it may receive a sample: the sensed output voltage and the averaged current-monitor level, both as unsigned millivolt codes. Alongside the sample it reads these plain control inputs:

- the target DAC code;
- two enable lines;
- a supply power-on-reset status;
- a VID-valid flag and a VID off-code flag;
- a soft-start-complete flag.

From these it decides two things. The first is the override applied to every phase's PWM: pass it through, pull it low, or float it. The second is whether power-good may be raised.

Overvoltage protection is live as soon as the supply is up, even with the regulator disabled. Until a valid VID has been seen after soft-start, the trip point is a fixed level. After that it tracks the DAC target with an offset. A trip latches. While latched, the phases alternate between a low crowbar and a floating state with hysteresis. Only a power-on reset or a drop of an enable clears the latch; changing the VID does not.

An overcurrent level on the monitor input latches a shutdown. Undervoltage below half the target withholds power-good. Power-good rises only after a fixed number of consecutive qualifying cycles.

The sample input is valid/ready. The block never applies back-pressure: `samp_ready` is always high, and a sample is taken on every cycle in which `samp_valid` is high. In a cycle without a valid sample, the block makes no new comparison.

Top module: `vr_fault_supervisor`

## Requirements
- R1: While no valid VID has been recorded, a valid sample with `vsen_mv` strictly above 1273 trips overvoltage, and 1273 itself does not.
- R2: After a cycle with both enables high, `ss_done` high and `vid_valid` high, from the next cycle on the trip level is `dac_mv` + 175 (strictly above). This lasts until an enable drops or `por_ok` falls.
- R3: In the same cycle as a valid sample trips overvoltage, every phase override field reads 2'b01 (force low), and `ov_latched` reads 1.
- R4: While latched, a valid sample strictly below `dac_mv` + 75 switches every phase to 2'b10 (high impedance). A later trip returns them to 2'b01. Samples in between keep the current state.
- R5: `ov_latched` stays set while `por_ok` and both enables stay high, whatever `dac_mv` or `vid_valid` do. It clears on a cycle with `por_ok` low, or with an enable low and no trip.
- R6: With `por_ok` high and an enable low, overvoltage is still detected and forces every phase to 2'b01.
- R7: A valid sample with `vsen_mv` below `dac_mv` shifted right by one holds `pgood` low. The last undervoltage verdict holds through cycles without a valid sample.
- R8: A valid sample with `imon_mv` strictly above 1110 sets `oc_latched`. This puts every phase at 2'b10 unless overvoltage is latched, and holds `pgood` low. It clears only when an enable drops or `por_ok` falls.
- R9: `pgood` is high only after `PG_DELAY` consecutive clock edges with all qualifying conditions true. Any break restarts the count from zero.
- R10: `pgood` is low whenever `por_ok` is low, either enable is low, `vid_off` is high, or `ss_done` is low.
- R11: Each phase's override field is 2 bits at [2p+1:2p]. It is 2'b00 (pass) only with `por_ok` high, both enables high, `vid_off` low and no latched fault. Otherwise it is 2'b10, except for the crowbar state, which is 2'b01. The code 2'b11 never appears.
- R12: With `samp_valid` low, the sample values have no effect, and `samp_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on-reset threshold |
| en_a | input | 1 | First enable |
| en_b | input | 1 | Second enable |
| vid_valid | input | 1 | VID code recognised as valid |
| vid_off | input | 1 | VID off-code present |
| ss_done | input | 1 | Soft-start complete |
| dac_mv | input | DW | Target voltage code, mV |
| samp_valid | input | 1 | Sample present this cycle |
| samp_ready | output | 1 | Sample accepted (always 1) |
| vsen_mv | input | DW | Sensed differential output voltage, mV |
| imon_mv | input | DW | Averaged current-monitor level, mV |
| pgood | output | 1 | Power-good |
| pwm_ovr | output | 2*NPH | Per-phase override codes |
| ov_latched | output | 1 | Overvoltage latch state |
| oc_latched | output | 1 | Overcurrent latch state |

## Verification
The embedded assertions check the following every cycle:

- a trip forces the crowbar code on the outputs;
- a latched fault or an undervoltage verdict keeps `pgood` low;
- a missing enable, supply or soft-start keeps `pgood` low;
- the overvoltage latch holds while powered and enabled;
- no phase ever shows the unused code;
- power-good rises only out of a qualifying cycle.

The following only the bench's scenarios can show, by comparing against a behavioural model on every clock:

- the exact trip and release boundaries;
- the switch of the trip level from the fixed value to the tracked value;
- the alternation between crowbar and floating across repeated excursions;
- that a VID change leaves the latch alone;
- the exact delay and the restart of power-good after a glitch.

// File: rtl/vrfs_pkg.sv
package vrfs_pkg;
  typedef enum logic [1:0] {
    OVR_PASS = 2'b00,
    OVR_LOW  = 2'b01,
    OVR_HIZ  = 2'b10
  } ovr_e;
endpackage

// File: rtl/vrfs_compare.sv
module vrfs_compare #(
  parameter int DW          = 12,
  parameter int OV_FIXED_MV = 1273,
  parameter int OV_OFS_MV   = 175,
  parameter int REL_OFS_MV  = 75,
  parameter int OC_LIM_MV   = 1110
) (
  input  logic          samp_valid,
  input  logic [DW-1:0] vsen_mv,
  input  logic [DW-1:0] imon_mv,
  input  logic [DW-1:0] dac_mv,
  input  logic          track_i,
  output logic          ov_hit,
  output logic          rel_hit,
  output logic          uv_hit,
  output logic          oc_hit
);
  localparam int XW = DW + 1;

  logic [XW-1:0] vs_x, dac_x, ov_thr, rel_thr;

  assign vs_x    = {1'b0, vsen_mv};
  assign dac_x   = {1'b0, dac_mv};
  assign ov_thr  = track_i ? (dac_x + XW'(OV_OFS_MV)) : XW'(OV_FIXED_MV);
  assign rel_thr = dac_x + XW'(REL_OFS_MV);

  assign ov_hit  = samp_valid && (vs_x > ov_thr);
  assign rel_hit = samp_valid && (vs_x < rel_thr);
  assign uv_hit  = samp_valid && (vsen_mv < (dac_mv >> 1));
  assign oc_hit  = samp_valid && ({1'b0, imon_mv} > XW'(OC_LIM_MV));
endmodule

// File: rtl/vrfs_ovp.sv
module vrfs_ovp (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic enabled,
  input  logic ov_hit,
  input  logic rel_hit,
  output logic latch_d,
  output logic crow_d
);
  logic latch_q, crow_q;

  always_comb begin
    if (!por_ok)       latch_d = 1'b0;
    else if (ov_hit)   latch_d = 1'b1;
    else if (!enabled) latch_d = 1'b0;
    else               latch_d = latch_q;

    if (!latch_d)      crow_d = 1'b0;
    else if (ov_hit)   crow_d = 1'b1;
    else if (rel_hit)  crow_d = 1'b0;
    else               crow_d = crow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      crow_q  <= 1'b0;
    end else begin
      latch_q <= latch_d;
      crow_q  <= crow_d;
    end
  end

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (por_ok && enabled && latch_q) |-> latch_d); // R5
endmodule

// File: rtl/vrfs_pg_timer.sv
module vrfs_pg_timer #(
  parameter int PG_DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_i,
  output logic pg_o
);
  localparam int CW = $clog2(PG_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(PG_DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!qual_i)        cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign pg_o = qual_i && (cnt_q == LAST);

  AST_PG_FROM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_o) |-> $past(qual_i)); // R9
endmodule

// File: rtl/vr_fault_supervisor.sv
module vr_fault_supervisor
  import vrfs_pkg::*;
#(
  parameter int DW          = 12,
  parameter int NPH         = 4,
  parameter int PG_DELAY    = 16,
  parameter int OV_FIXED_MV = 1273,
  parameter int OV_OFS_MV   = 175,
  parameter int REL_OFS_MV  = 75,
  parameter int OC_LIM_MV   = 1110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok,
  input  logic             en_a,
  input  logic             en_b,
  input  logic             vid_valid,
  input  logic             vid_off,
  input  logic             ss_done,
  input  logic [DW-1:0]    dac_mv,
  input  logic             samp_valid,
  output logic             samp_ready,
  input  logic [DW-1:0]    vsen_mv,
  input  logic [DW-1:0]    imon_mv,
  output logic             pgood,
  output logic [2*NPH-1:0] pwm_ovr,
  output logic             ov_latched,
  output logic             oc_latched
);
  logic enabled, powered_on;
  logic ov_hit, rel_hit, uv_hit, oc_hit;
  logic track_q, track_d;
  logic oc_q, oc_d;
  logic uv_q, uv_eff;
  logic ovl_d, crow_d, qual;
  ovr_e mode;

  assign enabled    = en_a && en_b;
  assign powered_on = por_ok && enabled;
  assign samp_ready = 1'b1;

  vrfs_compare #(
    .DW(DW), .OV_FIXED_MV(OV_FIXED_MV), .OV_OFS_MV(OV_OFS_MV),
    .REL_OFS_MV(REL_OFS_MV), .OC_LIM_MV(OC_LIM_MV)
  ) cmp_i (
    .samp_valid(samp_valid), .vsen_mv(vsen_mv), .imon_mv(imon_mv),
    .dac_mv(dac_mv), .track_i(track_q),
    .ov_hit(ov_hit), .rel_hit(rel_hit), .uv_hit(uv_hit), .oc_hit(oc_hit)
  );

  vrfs_ovp ovp_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .enabled(enabled),
    .ov_hit(ov_hit), .rel_hit(rel_hit), .latch_d(ovl_d), .crow_d(crow_d)
  );

  always_comb begin
    if (!powered_on)                 track_d = 1'b0;
    else if (vid_valid && ss_done)   track_d = 1'b1;
    else                             track_d = track_q;

    if (!powered_on)   oc_d = 1'b0;
    else if (oc_hit)   oc_d = 1'b1;
    else               oc_d = oc_q;
  end

  assign uv_eff = samp_valid ? uv_hit : uv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      track_q <= 1'b0;
      oc_q    <= 1'b0;
      uv_q    <= 1'b0;
    end else begin
      track_q <= track_d;
      oc_q    <= oc_d;
      uv_q    <= uv_eff;
    end
  end

  assign qual = powered_on && ss_done && !vid_off && !uv_eff && !ovl_d && !oc_d;

  vrfs_pg_timer #(.PG_DELAY(PG_DELAY)) pg_i (
    .clk(clk), .rst_n(rst_n), .qual_i(qual), .pg_o(pgood)
  );

  always_comb begin
    if (!por_ok)                   mode = OVR_HIZ;
    else if (ovl_d)                mode = crow_d ? OVR_LOW : OVR_HIZ;
    else if (oc_d)                 mode = OVR_HIZ;
    else if (!enabled || vid_off)  mode = OVR_HIZ;
    else                           mode = OVR_PASS;
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign pwm_ovr[2*p +: 2] = mode;

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_ovr[2*p +: 2] != 2'b11); // R11
    AST_CROWBAR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      ov_hit |-> (pwm_ovr[2*p +: 2] == 2'b01)); // R3
    AST_RELEASE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_latched && rel_hit && !ov_hit) |-> (pwm_ovr[2*p +: 2] == 2'b10)); // R4
  end

  assign ov_latched = ovl_d;
  assign oc_latched = oc_d;

  AST_PG_FAULT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_latched || oc_latched) |-> !pgood); // R8
  AST_PG_UV_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    uv_hit |-> !pgood); // R7
  AST_PG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !en_a || !en_b || vid_off || !ss_done) |-> !pgood); // R10
endmodule

// File: tb/vr_fault_supervisor_tb_top.sv
module vr_fault_supervisor_tb_top;
  localparam int DW = 12;
  localparam int NPH = 4;
  localparam int DLY = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok = 1'b0, en_a = 1'b0, en_b = 1'b0;
  logic vid_valid = 1'b0, vid_off = 1'b0, ss_done = 1'b0;
  logic samp_valid = 1'b0;
  logic [DW-1:0] dac_mv = 12'd1000, vsen_mv = 12'd0, imon_mv = 12'd0;
  logic samp_ready, pgood, ov_latched, oc_latched;
  logic [2*NPH-1:0] pwm_ovr;

  always #2 clk = ~clk;

  vr_fault_supervisor #(.DW(DW), .NPH(NPH), .PG_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_a(en_a), .en_b(en_b),
    .vid_valid(vid_valid), .vid_off(vid_off), .ss_done(ss_done),
    .dac_mv(dac_mv), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .vsen_mv(vsen_mv), .imon_mv(imon_mv), .pgood(pgood), .pwm_ovr(pwm_ovr),
    .ov_latched(ov_latched), .oc_latched(oc_latched)
  );

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R11";

  // behavioural reference state
  bit s_ovl, s_crl, s_ocl, s_trk, s_uv;
  int s_cnt;
  // reference next values / outputs
  bit n_ovl, n_crl, n_ocl, n_trk, n_uv, m_pg, m_qual;
  logic [1:0] m_code;

  task automatic model_eval();
    int vs, dac, thr;
    bit en, ovn, reln, uvn, ocn;
    vs = int'(vsen_mv); dac = int'(dac_mv);
    en = en_a && en_b;
    thr = s_trk ? dac + 175 : 1273;
    ovn  = samp_valid && vs > thr;
    reln = samp_valid && vs < dac + 75;
    uvn  = samp_valid && (vs < dac / 2);
    ocn  = samp_valid && int'(imon_mv) > 1110;
    n_ovl = !por_ok ? 0 : ovn ? 1 : !en ? 0 : s_ovl;
    n_crl = !n_ovl ? 0 : ovn ? 1 : reln ? 0 : s_crl;
    n_ocl = (!por_ok || !en) ? 0 : ocn ? 1 : s_ocl;
    n_trk = (!por_ok || !en) ? 0 : (vid_valid && ss_done) ? 1 : s_trk;
    n_uv  = samp_valid ? uvn : s_uv;
    m_qual = por_ok && en && ss_done && !vid_off && !n_uv && !n_ovl && !n_ocl;
    m_pg = m_qual && (s_cnt >= DLY);
    if (!por_ok) m_code = 2'b10;
    else if (n_ovl) m_code = n_crl ? 2'b01 : 2'b10;
    else if (n_ocl || !en || vid_off) m_code = 2'b10;
    else m_code = 2'b00;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ovl = 0; s_crl = 0; s_ocl = 0; s_trk = 0; s_uv = 0; s_cnt = 0;
    end else begin
      model_eval();
      s_ovl = n_ovl; s_crl = n_crl; s_ocl = n_ocl; s_trk = n_trk; s_uv = n_uv;
      s_cnt = m_qual ? ((s_cnt < DLY) ? s_cnt + 1 : DLY) : 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    model_eval();
    checks++;
    if (pgood !== m_pg) begin
      errors++; $display("FAIL %s pgood actual=%b expected=%b t=%0t", tag, pgood, m_pg, $time);
    end
    if (ov_latched !== n_ovl) begin
      errors++; $display("FAIL %s ov_latched actual=%b expected=%b t=%0t", tag, ov_latched, n_ovl, $time);
    end
    if (oc_latched !== n_ocl) begin
      errors++; $display("FAIL %s oc_latched actual=%b expected=%b t=%0t", tag, oc_latched, n_ocl, $time);
    end
    if (pwm_ovr !== {NPH{m_code}}) begin
      errors++; $display("FAIL %s pwm_ovr actual=%h expected=%h t=%0t", tag, pwm_ovr, {NPH{m_code}}, $time);
    end
    if (samp_ready !== 1'b1) begin
      errors++; $display("FAIL R12 samp_ready actual=%b expected=1", samp_ready);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // directed check taken at a falling edge, before inputs change
  task automatic expect_bit(string rq, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s %s actual=%b expected=%b", rq, nm, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; $display("FAIL R9 watchdog actual=hung expected=done");
      summary();
    end
  end

  task automatic bring_up();
    por_ok = 1; en_a = 1; en_b = 1; vid_off = 0;
    samp_valid = 1; vsen_mv = 12'd1000; imon_mv = 12'd500;
    ss_done = 1; vid_valid = 1;
  endtask

  initial begin
    // reset state
    tag = "R10";
    step(3);
    expect_bit("R10", "pgood in reset", pgood, 1'b0);
    expect_bit("R11", "float in reset", pwm_ovr[1:0] == 2'b10, 1'b1);
    rst_n = 1;
    step(2);

    // R11 / R9: bring-up, soft-start then delay
    tag = "R9";
    por_ok = 1; en_a = 1; en_b = 1; samp_valid = 1; vsen_mv = 12'd1000; imon_mv = 12'd500;
    step(4);
    expect_bit("R11", "pass while running", pwm_ovr == '0, 1'b1);
    expect_bit("R10", "no pgood before soft-start", pgood, 1'b0);
    ss_done = 1; vid_valid = 1;
    step(DLY);
    expect_bit("R9", "pgood after delay", pgood, 1'b1);

    // R12: invalid samples ignored
    tag = "R12";
    samp_valid = 0; vsen_mv = 12'd2000; imon_mv = 12'd2000;
    step(3);
    expect_bit("R12", "no trip from invalid sample", ov_latched, 1'b0);
    expect_bit("R12", "pgood held", pgood, 1'b1);
    samp_valid = 1; vsen_mv = 12'd1000; imon_mv = 12'd500;
    step(2);

    // R2 boundary, R3 trip, R4 hysteresis
    tag = "R2";
    vsen_mv = 12'd1175; step(2);
    expect_bit("R2", "no trip at equal", ov_latched, 1'b0);
    tag = "R3";
    vsen_mv = 12'd1176; step(1);
    expect_bit("R3", "latched", ov_latched, 1'b1);
    tag = "R4";
    vsen_mv = 12'd1100; step(2);
    vsen_mv = 12'd1075; step(2);
    vsen_mv = 12'd1074; step(2);
    vsen_mv = 12'd1150; step(2);
    vsen_mv = 12'd1300; step(2);
    vsen_mv = 12'd1000; step(2);

    // R5: VID changes keep latch
    tag = "R5";
    dac_mv = 12'd900; vid_valid = 0; step(3);
    vid_valid = 1; dac_mv = 12'd1000; step(2);
    expect_bit("R5", "latch kept over VID change", ov_latched, 1'b1);
    en_a = 0; step(2);
    expect_bit("R5", "cleared by enable drop", ov_latched, 1'b0);

    // R1 / R6: fixed level while disabled
    tag = "R1";
    vsen_mv = 12'd1273; step(2);
    tag = "R6";
    vsen_mv = 12'd1274; step(1);
    expect_bit("R6", "crowbar while disabled", pwm_ovr[1:0] == 2'b01, 1'b1);
    vsen_mv = 12'd1000; step(2);
    por_ok = 0; step(2);
    por_ok = 1; step(1);

    // R1 while enabled but before VID recorded
    tag = "R1";
    en_a = 1; ss_done = 0; vid_valid = 0; vsen_mv = 12'd1250; step(3);
    vsen_mv = 12'd1280; step(2);
    vsen_mv = 12'd1000; step(1);
    en_b = 0; step(2); en_b = 1; step(1);

    // R7 / R9 undervoltage and restart
    tag = "R7";
    bring_up(); step(DLY + 2);
    vsen_mv = 12'd499; step(2);
    expect_bit("R7", "pgood drops on UV", pgood, 1'b0);
    samp_valid = 0; vsen_mv = 12'd1000; step(2);
    expect_bit("R7", "UV verdict held", pgood, 1'b0);
    tag = "R9";
    samp_valid = 1; vsen_mv = 12'd500; step(DLY - 3);
    vsen_mv = 12'd400; step(1);
    vsen_mv = 12'd1000; step(DLY - 1);
    expect_bit("R9", "restarted count", pgood, 1'b0);
    step(3);

    // R10 pgood withdraw
    tag = "R10";
    vid_off = 1; step(2);
    expect_bit("R11", "float on off-code", pwm_ovr[1:0] == 2'b10, 1'b1);
    vid_off = 0; step(DLY + 2);
    en_b = 0; step(2); en_b = 1; step(DLY + 2);
    ss_done = 0; step(2); ss_done = 1; step(DLY + 2);

    // R8 overcurrent
    tag = "R8";
    imon_mv = 12'd1110; step(2);
    expect_bit("R8", "no trip at limit", oc_latched, 1'b0);
    imon_mv = 12'd1111; step(1);
    imon_mv = 12'd500; step(3);
    expect_bit("R8", "oc sticky", oc_latched, 1'b1);
    vid_valid = 0; step(2);
    en_a = 0; step(2);
    expect_bit("R8", "oc cleared", oc_latched, 1'b0);
    en_a = 1; vid_valid = 1; step(DLY + 3);

    tag = "R11";
    step(4);
    summary();
  end
endmodule